// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This block sits beside a processor's sequencer and decides, each time an instruction boundary is signalled, whether to divert execution into an interrupt handler. It keeps a master enable flag and a separate deferred-enable flag, and a small request register that hardware sources and software can both write. A source can be taken only if its request bit and its mask bit are both set.

When an interrupt is accepted, the controller starts a fixed-length dispatch sequence. In the first cycle it asks for the interrupted program counter to be saved and pulses a clear for the serviced request. In the last cycle it loads the handler address. Among the waiting sources the lowest-numbered one is served. Handler addresses begin at 0x40 and are 8 bytes apart. The enable-interrupts operation takes effect one boundary late. Return-from-interrupt re-enables at once, and the disable operation clears both flags.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: Synchronous reset (rst=1) clears the request register, the master enable, the deferred-enable flag, busy and every dispatch output. It also sets vec_addr and push_pc to 0.
- R2: A dispatch starts only on a cycle where boundary=1, busy=0, ime=1 and (req_flags & en_mask) is nonzero. Otherwise busy stays 0.
- R3: The winner is the lowest set bit index i of (req_flags & en_mask). vec_addr equals 0x40 + 8*i, so bit 1 gives 0x48 and bit 4 gives 0x60.
- R4: The edge that starts a dispatch clears ime, ei_pending and request bit i. During the first busy cycle, clr_onehot equals 1<<i. At all other times clr_onehot is 0.
- R5: push_req is 1 only in the first busy cycle. In that cycle push_pc holds the cur_pc value present on the accepting boundary.
- R6: busy is 1 for exactly 5 consecutive cycles after the accepting edge. pc_load is 1 only in the fifth of those cycles.
- R7: op_ei sets ei_pending without changing ime. On a later boundary, if ime=0 and ei_pending=1, then ime becomes 1, ei_pending becomes 0, and no dispatch starts on that boundary.
- R8: op_reti sets ime to 1 on the next edge and clears ei_pending.
- R9: op_di clears both ime and ei_pending. When strobes coincide, op_di beats op_reti, and op_reti beats op_ei.
- R10: While busy=1, boundary, op_ei, op_di and op_reti have no effect.
- R11: sw_wr_en=1 replaces the request register with sw_wr_data. Bits in src_set are ORed in after any write or clear, so a set and a dispatch clear of the same bit in one cycle leave the bit at 1.
- R12: On the cycle a dispatch starts, any enable, disable or return strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 5 | Hardware set pulses, one per source |
| sw_wr_en | input | 1 | Software write strobe for the request register |
| sw_wr_data | input | 5 | Value written by software |
| en_mask | input | 5 | Per-source enable mask |
| boundary | input | 1 | Instruction-boundary strobe, the decision point |
| op_ei | input | 1 | Enable-interrupts operation retired |
| op_di | input | 1 | Disable-interrupts operation retired |
| op_reti | input | 1 | Return-from-interrupt operation retired |
| cur_pc | input | 16 | Program counter to save on dispatch |
| req_flags | output | 5 | Request register contents |
| ime | output | 1 | Master interrupt enable |
| ei_pending | output | 1 | Deferred enable request |
| busy | output | 1 | Dispatch sequence in progress |
| push_req | output | 1 | Request to push push_pc onto the stack |
| push_pc | output | 16 | Program counter captured at dispatch |
| clr_onehot | output | 5 | Pulse marking the serviced request bit |
| pc_load | output | 1 | Load vec_addr into the program counter |
| vec_addr | output | 16 | Handler address of the current dispatch |

## Verification
The assertions assume that every input is synchronous to clk and stable around the rising edge. They also assume that strobes may arrive in any combination, including all at once and during busy. The stimulus changes inputs only on the falling edge. It draws strobe sets and request pulses that overlap freely and keeps boundary frequent, so dispatches often begin while other sources are still waiting. Directed sequences cover the deferred enable, a set colliding with a clear, strobe priority, and strobes dropped on the dispatch edge.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_EI   = 2'd1,
        OP_DI   = 2'd2,
        OP_RETI = 2'd3
    } en_op_e;

    typedef struct packed {
        logic ime;
        logic ask;
    } en_state_t;

    // Strobe priority: disable over return over enable.
    function automatic en_op_e decode_op(logic ei, logic di, logic reti);
        if (di)   return OP_DI;
        if (reti) return OP_RETI;
        if (ei)   return OP_EI;
        return OP_NONE;
    endfunction

    function automatic en_state_t next_en(en_state_t cur, logic take,
                                          logic bnd_ok, logic idle, en_op_e op);
        en_state_t n;
        n = cur;
        if (take) begin
            n.ime = 1'b0;
            n.ask = 1'b0;
        end else begin
            if (bnd_ok && !cur.ime && cur.ask) begin
                n.ime = 1'b1;
                n.ask = 1'b0;
            end
            if (idle) begin
                case (op)
                    OP_DI:   begin n.ime = 1'b0; n.ask = 1'b0; end
                    OP_RETI: begin n.ime = 1'b1; n.ask = 1'b0; end
                    OP_EI:   n.ask = 1'b1;
                    default: ;
                endcase
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick #(
    parameter int unsigned N     = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     cand,
    output logic             any_hit,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign seen[g+1] = seen[g] | cand[g];
        assign grant[g]  = cand[g] & ~seen[g];
    end

    assign any_hit = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        assert ($onehot0(grant)) else $error("AST_GRANT_ONEHOT"); // R3
    end
endmodule

// File: rtl/irqd_req_reg.sv
module irqd_req_reg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_pulse,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] req_q
);
    logic [N-1:0] base;
    logic [N-1:0] req_d;

    always_comb begin
        base  = wr_en ? wr_data : req_q;
        req_d = (base & ~clr_mask) | set_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((req_q & $past(set_pulse)) == $past(set_pulse))) else $error("AST_SET_WINS"); // R11
endmodule

// File: rtl/irqd_enable_ctl.sv
module irqd_enable_ctl
    import irqd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bnd_ok,
    input  logic take,
    input  logic busy,
    input  logic op_ei,
    input  logic op_di,
    input  logic op_reti,
    output logic ime,
    output logic ask
);
    en_state_t st_q, st_d;
    en_op_e    op;

    always_comb begin
        op   = decode_op(op_ei, op_di, op_reti);
        st_d = next_en(st_q, take, bnd_ok, !busy, op);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ime = st_q.ime;
    assign ask = st_q.ask;

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        take |=> (!ime && !ask)) else $error("AST_TAKE_CLEARS"); // R4
    AST_RETI_NOW: assert property (@(posedge clk) disable iff (rst)
        (op_reti && !op_di && !busy && !take) |=> (ime && !ask)) else $error("AST_RETI_NOW"); // R8
    AST_DI_NOW: assert property (@(posedge clk) disable iff (rst)
        (op_di && !busy) |=> (!ime && !ask)) else $error("AST_DI_NOW"); // R9
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ime) && $stable(ask))) else $error("AST_BUSY_FROZEN"); // R10
endmodule

// File: rtl/irqd_dispatch_seq.sv
module irqd_dispatch_seq #(
    parameter int unsigned N          = 5,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned PC_W       = 16,
    parameter int unsigned VEC_BASE   = 'h40,
    parameter int unsigned VEC_STRIDE = 8,
    parameter int unsigned CYCLES     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [N-1:0]     win_onehot,
    input  logic [PC_W-1:0]  cur_pc,
    output logic             busy,
    output logic             push_req,
    output logic [PC_W-1:0]  push_pc,
    output logic [N-1:0]     clr_onehot,
    output logic             pc_load,
    output logic [PC_W-1:0]  vec_addr
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [N-1:0]     win_q;
    logic [PC_W-1:0]  vec_d;

    assign vec_d = PC_W'(VEC_BASE + VEC_STRIDE * win_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            win_q    <= '0;
            push_pc  <= '0;
            vec_addr <= '0;
        end else if (take) begin
            busy     <= 1'b1;
            cnt_q    <= '0;
            win_q    <= win_onehot;
            push_pc  <= cur_pc;
            vec_addr <= vec_d;
        end else if (busy) begin
            if (cnt_q == LAST) busy  <= 1'b0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign push_req   = busy && (cnt_q == '0);
    assign pc_load    = busy && (cnt_q == LAST);
    assign clr_onehot = push_req ? win_q : '0;

    AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy) else $error("AST_LOAD_ENDS"); // R6
    AST_PUSH_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> push_req) else $error("AST_PUSH_FIRST"); // R5
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        busy |-> $onehot0(clr_onehot)) else $error("AST_CLR_ONEHOT"); // R4
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
    parameter int unsigned NUM_SRC         = 5,
    parameter int unsigned PC_W            = 16,
    parameter int unsigned VEC_BASE        = 'h40,
    parameter int unsigned VEC_STRIDE      = 8,
    parameter int unsigned DISPATCH_CYCLES = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               sw_wr_en,
    input  logic [NUM_SRC-1:0] sw_wr_data,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic               boundary,
    input  logic               op_ei,
    input  logic               op_di,
    input  logic               op_reti,
    input  logic [PC_W-1:0]    cur_pc,
    output logic [NUM_SRC-1:0] req_flags,
    output logic               ime,
    output logic               ei_pending,
    output logic               busy,
    output logic               push_req,
    output logic [PC_W-1:0]    push_pc,
    output logic [NUM_SRC-1:0] clr_onehot,
    output logic               pc_load,
    output logic [PC_W-1:0]    vec_addr
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic               bnd_ok;
    logic               any_hit;
    logic               take;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;

    assign bnd_ok = boundary && !busy;
    assign take   = bnd_ok && ime && any_hit;

    irqd_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .cand    (req_flags & en_mask),
        .any_hit (any_hit),
        .grant   (grant),
        .idx     (win_idx)
    );

    irqd_req_reg #(.N(NUM_SRC)) u_req (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (src_set),
        .wr_en     (sw_wr_en),
        .wr_data   (sw_wr_data),
        .clr_mask  (grant & {NUM_SRC{take}}),
        .req_q     (req_flags)
    );

    irqd_enable_ctl u_en (
        .clk     (clk),
        .rst     (rst),
        .bnd_ok  (bnd_ok),
        .take    (take),
        .busy    (busy),
        .op_ei   (op_ei),
        .op_di   (op_di),
        .op_reti (op_reti),
        .ime     (ime),
        .ask     (ei_pending)
    );

    irqd_dispatch_seq #(
        .N          (NUM_SRC),
        .IDX_W      (IDX_W),
        .PC_W       (PC_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE),
        .CYCLES     (DISPATCH_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .win_idx    (win_idx),
        .win_onehot (grant),
        .cur_pc     (cur_pc),
        .busy       (busy),
        .push_req   (push_req),
        .push_pc    (push_pc),
        .clr_onehot (clr_onehot),
        .pc_load    (pc_load),
        .vec_addr   (vec_addr)
    );

    AST_NO_TAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ime && !busy) |=> !push_req) else $error("AST_NO_TAKE_WHEN_OFF"); // R2
    AST_PROMOTE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (boundary && !busy && !ime && ei_pending) |=> !busy) else $error("AST_PROMOTE_NO_TAKE"); // R7
endmodule

// File: tb/test_irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module test_irq_dispatch_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  src_set, sw_wr_data, en_mask;
    logic        sw_wr_en, boundary, op_ei, op_di, op_reti;
    logic [15:0] cur_pc;
    logic [4:0]  req_flags, clr_onehot;
    logic        ime, ei_pending, busy, push_req, pc_load;
    logic [15:0] push_pc, vec_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_dispatch_ctrl i_irq_dispatch_ctrl (
        .clk(clk), .rst(rst), .src_set(src_set), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .en_mask(en_mask), .boundary(boundary),
        .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti), .cur_pc(cur_pc),
        .req_flags(req_flags), .ime(ime), .ei_pending(ei_pending), .busy(busy),
        .push_req(push_req), .push_pc(push_pc), .clr_onehot(clr_onehot),
        .pc_load(pc_load), .vec_addr(vec_addr)
    );

    // Reference model, written from the requirements
    logic [4:0]  m_req, m_win;
    logic        m_ime, m_ask, m_busy;
    int          m_cnt;
    logic [15:0] m_vec, m_pc;

    function automatic int lowest(logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_req = '0; m_ime = 0; m_ask = 0; m_busy = 0; m_cnt = 0;
            m_win = '0; m_vec = '0; m_pc = '0;
        end else begin
            logic tk;
            int   w;
            logic [4:0] nb;
            w  = lowest(m_req & en_mask);
            tk = boundary && !m_busy && m_ime && (w >= 0);
            nb = sw_wr_en ? sw_wr_data : m_req;
            if (tk) nb[w] = 1'b0;
            m_req = nb | src_set;
            if (tk) begin
                m_ime = 0; m_ask = 0;
            end else if (!m_busy) begin
                if (boundary && !m_ime && m_ask) begin m_ime = 1; m_ask = 0; end
                if (op_di) begin m_ime = 0; m_ask = 0; end
                else if (op_reti) begin m_ime = 1; m_ask = 0; end
                else if (op_ei) m_ask = 1;
            end
            if (tk) begin
                m_busy = 1; m_cnt = 0; m_win = 5'd1 << w;
                m_vec = 16'h0040 + 16'(8 * w); m_pc = cur_pc;
            end else if (m_busy) begin
                if (m_cnt == 4) m_busy = 0; else m_cnt++;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic p, l;
        p = m_busy && (m_cnt == 0);
        l = m_busy && (m_cnt == 4);
        chk("R11 req_flags", 32'(req_flags), 32'(m_req));
        chk("R7 ime", 32'(ime), 32'(m_ime));
        chk("R7 ei_pending", 32'(ei_pending), 32'(m_ask));
        chk("R6 busy", 32'(busy), 32'(m_busy));
        chk("R5 push_req", 32'(push_req), 32'(p));
        chk("R5 push_pc", 32'(push_pc), 32'(m_pc));
        chk("R4 clr_onehot", 32'(clr_onehot), 32'(p ? m_win : 5'd0));
        chk("R6 pc_load", 32'(pc_load), 32'(l));
        chk("R3 vec_addr", 32'(vec_addr), 32'(m_vec));
    endtask

    task automatic idle_inputs();
        src_set = '0; sw_wr_en = 0; sw_wr_data = '0; boundary = 0;
        op_ei = 0; op_di = 0; op_reti = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; idle_inputs(); en_mask = '0; cur_pc = '0;
        repeat (3) @(negedge clk);
        compare_all();
        chk("R1 ime after reset", 32'(ime), 0);
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R1 req after reset", 32'(req_flags), 0);
        rst = 0;
        step();

        sw_wr_en = 1; sw_wr_data = 5'b10110; en_mask = 5'h1F;
        step();
        chk("R11 sw write", 32'(req_flags), 32'h16);
        boundary = 1;
        step();
        chk("R2 no take with ime off", 32'(busy), 0);
        op_ei = 1;
        step();
        chk("R7 ei sets pending only", 32'({ime, ei_pending}), 32'h1);
        boundary = 1;
        step();
        chk("R7 promote without take", 32'({ime, ei_pending, busy}), 32'h4);
        boundary = 1; cur_pc = 16'h1234;
        step();
        chk("R3 R4 R5 take bit1", 32'({busy, push_req, clr_onehot}), 32'h62);
        chk("R5 push pc", 32'(push_pc), 32'h1234);
        chk("R4 serviced bit cleared", 32'(req_flags), 32'h14);
        for (int k = 0; k < 4; k++) begin
            boundary = 1; op_reti = 1; op_ei = 1;
            step();
        end
        chk("R6 pc_load vector 0x48", 32'({pc_load, vec_addr}), 32'h10048);
        chk("R10 strobes ignored while busy", 32'({ime, ei_pending}), 0);
        step();
        chk("R6 busy ends after 5", 32'(busy), 0);
        op_reti = 1;
        step();
        chk("R8 reti enables at once", 32'(ime), 1);
        en_mask = 5'b10000; boundary = 1;
        step();
        repeat (4) step();
        chk("R3 vector for bit4", 32'(vec_addr), 32'h60);
        step();
        op_reti = 1;
        step();
        en_mask = 5'b00100; boundary = 1; src_set = 5'b00100;
        step();
        chk("R11 set beats clear", 32'({req_flags[2], clr_onehot}), 32'h24);
        repeat (5) step();
        op_di = 1; op_ei = 1;
        step();
        chk("R9 di beats ei", 32'({ime, ei_pending}), 0);
        op_ei = 1; op_reti = 1;
        step();
        chk("R9 reti beats ei", 32'({ime, ei_pending}), 32'h2);
        boundary = 1; op_reti = 1; op_ei = 1;
        step();
        chk("R12 strobes dropped on take", 32'({busy, ime, ei_pending}), 32'h4);
        repeat (5) step();

        for (int n = 0; n < 4000; n++) begin
            int r;
            boundary = ($urandom % 100) < 45;
            r = $urandom % 100;
            op_ei   = (r < 6) || (r == 20);
            op_di   = (r >= 6 && r < 9) || (r == 20);
            op_reti = (r >= 9 && r < 13) || (r == 21);
            src_set = (($urandom % 100) < 12) ? 5'($urandom) : 5'd0;
            sw_wr_en = ($urandom % 100) < 3;
            sw_wr_data = 5'($urandom);
            if (($urandom % 100) < 4) en_mask = 5'($urandom);
            cur_pc = 16'($urandom);
            @(negedge clk);
            compare_all();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule